// File: doc/BRIEF.md
# Boot Mode Latch and Bus Configuration

This block captures the chip's strap pins once, on the first clock edge after power-on reset is released, and holds that boot mode until the next power-on reset. Three straps are used. The first chooses between running self-contained and using the external bus. The second chooses whether the on-chip ROM is mapped. The third picks the starting data bus width for every external area.

From the held mode, the block does three jobs. It raises a standby request for the external bus controller and marks the bus pins as general-purpose ports when the chip runs self-contained. It decodes each access address into its area number and its target, either on-chip ROM or external memory, and reports the configured bus width of that area. It also keeps eight 2-bit width fields that software may rewrite through a simple write strobe and a combinational read port.

One write-protection rule applies. When the ROM strap says the ROM is off, area 0 is the boot device, and its width field is frozen at the reset value. A parameter selects which pair of widths the width strap chooses between.

Top module: `bcfg_top`

## Requirements
- R1: The three strap pins are captured on the first rising clock edge after `por_n` goes high; later changes on the pins have no effect on `bus_standby`, `pins_as_port`, the decode or the width fields until the next power-on reset.
- R2: A new power-on reset followed by release captures the new strap values, replacing the old mode and reloading every width field.
- R3: When the single-chip strap was captured high, `bus_standby` and `pins_as_port` are both 1; otherwise both are 0.
- R4: With ROM enabled, an address in area 0 whose half-select bit (bit 25) is 0 gives `acc_rom`=1 and `acc_ext`=0; with bit 25 set it gives `acc_rom`=0, and `acc_ext`=1 in external-bus mode. The area number on `acc_area` is address bits [28:26].
- R5: With ROM disabled, `acc_rom` is 0 for every address. In single-chip mode `acc_ext` is always 0. In external-bus mode every address that is not a ROM hit gives `acc_ext`=1.
- R6: Width codes are 00 = 8 bits, 01 = 16 bits, 10 = 32 bits and 11 = reserved. With the default `WIDE_PAIR`=0, a width strap of 0 loads 00 and a width strap of 1 loads 01 into all eight fields. With `WIDE_PAIR`=1 the same straps load 01 and 10.
- R7: With ROM disabled, writes to the area 0 field are ignored and it keeps its reset width, while writes to areas 1 to 7 take effect.
- R8: With ROM enabled, writes take effect on all eight fields, area 0 included.
- R9: A write of the reserved code 11 is ignored and the field keeps its previous value.
- R10: A write strobed on `cfg_we` is visible on `cfg_rdata` (combinational from `cfg_area`) after the next rising edge. `acc_width` shows the current field of the area addressed by `acc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_single | input | 1 | Strap: 1 = single-chip, 0 = external bus |
| strap_rom | input | 1 | Strap: 1 = on-chip ROM mapped |
| strap_wide | input | 1 | Strap: initial width select for all areas |
| acc_addr | input | ADDR_W (29) | Access address to decode |
| acc_area | output | AREA_W (3) | Decoded area number |
| acc_rom | output | 1 | Address targets on-chip ROM |
| acc_ext | output | 1 | Address targets external memory |
| acc_width | output | 2 | Width code of the addressed area |
| cfg_we | input | 1 | Width field write strobe |
| cfg_area | input | AREA_W (3) | Field index for write and read |
| cfg_wdata | input | 2 | Width code to write |
| cfg_rdata | output | 2 | Current width code of field `cfg_area` |
| bus_standby | output | 1 | Standby request to external bus controller |
| pins_as_port | output | 1 | Bus pins act as general-purpose ports |

## Verification
A wrong captured mode shows on `bus_standby`, `pins_as_port` and the ROM/external decode in the first cycle after reset release. It stays visible for the whole session because nothing rewrites it. A wrongly accepted or refused width write shows on `cfg_rdata` and on `acc_width` one clock after the strobe. The bench therefore reads the field back right after every write and compares it against a model that applies the area 0 lock and the reserved-code rule. A wrong half-select bit or a wrong area slice shows only on addresses near the boundary inside area 0. For that reason the addresses just below and at bit 25 are driven directly, in addition to random addresses.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

   typedef enum logic [1:0] {
      BW_8    = 2'b00,
      BW_16   = 2'b01,
      BW_32   = 2'b10,
      BW_RSVD = 2'b11
   } bus_width_e;

   typedef struct packed {
      logic single_chip;
      logic rom_en;
      logic wide_init;
   } boot_mode_t;

   // Width loaded at reset: the pair is chosen by the build, the member by the strap.
   function automatic bus_width_e reset_width(input logic wide_strap, input logic wide_pair);
      if (wide_pair)
         return wide_strap ? BW_32 : BW_16;
      else
         return wide_strap ? BW_16 : BW_8;
   endfunction

endpackage

// File: rtl/bcfg_mode_latch.sv
module bcfg_mode_latch
   import bcfg_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  boot_mode_t straps,
   output boot_mode_t mode_q,
   output logic       captured_q,
   output logic       capture_now
);

   // Capture happens on the single edge where captured_q is still low.
   assign capture_now = ~captured_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         captured_q <= 1'b0;
         mode_q     <= '0;
      end else if (capture_now) begin
         captured_q <= 1'b1;
         mode_q     <= straps;
      end
   end

endmodule

// File: rtl/bcfg_width_bank.sv
module bcfg_width_bank
   import bcfg_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter int AREA_W    = 3,
   parameter bit WIDE_PAIR = 1'b0,
   localparam int FIELD_W  = 2,
   localparam int FLAT_W   = NUM_AREAS * FIELD_W
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              load_init,
   input  logic              wide_strap,
   input  logic              rom_en,
   input  logic              wr_en,
   input  logic [AREA_W-1:0] wr_area,
   input  logic [FIELD_W-1:0] wr_code,
   input  logic [AREA_W-1:0] dec_area,
   output logic [FIELD_W-1:0] rd_code,
   output logic [FIELD_W-1:0] dec_code,
   output logic [FLAT_W-1:0] widths_flat
);

   bus_width_e init_code;
   logic       code_legal;
   logic       wr_live;

   assign init_code  = reset_width(wide_strap, WIDE_PAIR);
   assign code_legal = (wr_code != BW_RSVD);
   assign wr_live    = wr_en & code_legal & ~load_init;

   bus_width_e field_q [NUM_AREAS];

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      logic hit;
      logic accept;

      assign hit = wr_live && (wr_area == AREA_W'(g));

      if (g == 0) begin : g_boot_lock
         // The boot area is frozen when it is the boot device (ROM off).
         assign accept = hit & rom_en;
      end else begin : g_open
         assign accept = hit;
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            field_q[g] <= BW_8;
         else if (load_init)
            field_q[g] <= init_code;
         else if (accept)
            field_q[g] <= bus_width_e'(wr_code);
      end

      assign widths_flat[g*FIELD_W +: FIELD_W] = field_q[g];
   end

   assign rd_code  = field_q[wr_area];
   assign dec_code = field_q[dec_area];

endmodule

// File: rtl/bcfg_addr_decode.sv
module bcfg_addr_decode #(
   parameter int ADDR_W   = 29,
   parameter int AREA_LSB = 26,
   parameter int AREA_W   = 3,
   parameter int HALF_BIT = 25
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic              rom_en,
   input  logic              single_chip,
   output logic [AREA_W-1:0] area,
   output logic              to_rom,
   output logic              to_ext
);

   logic boot_area;
   logic lower_half;
   logic unused_addr;

   assign area       = addr[AREA_LSB +: AREA_W];
   assign boot_area  = (area == '0);
   assign lower_half = ~addr[HALF_BIT];
   assign unused_addr = ^addr;

   always_comb begin
      to_rom = rom_en & boot_area & lower_half;
      to_ext = ~single_chip & ~to_rom;
   end

endmodule

// File: rtl/bcfg_top.sv
module bcfg_top
   import bcfg_pkg::*;
#(
   parameter int ADDR_W    = 29,
   parameter int AREA_W    = 3,
   parameter int AREA_LSB  = 26,
   parameter int HALF_BIT  = 25,
   parameter bit WIDE_PAIR = 1'b0,
   localparam int NUM_AREAS = 1 << AREA_W,
   localparam int FIELD_W   = 2,
   localparam int FLAT_W    = NUM_AREAS * FIELD_W
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              strap_single,
   input  logic              strap_rom,
   input  logic              strap_wide,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [AREA_W-1:0] acc_area,
   output logic              acc_rom,
   output logic              acc_ext,
   output logic [1:0]        acc_width,
   input  logic              cfg_we,
   input  logic [AREA_W-1:0] cfg_area,
   input  logic [1:0]        cfg_wdata,
   output logic [1:0]        cfg_rdata,
   output logic              bus_standby,
   output logic              pins_as_port
);

   if (AREA_LSB + AREA_W > ADDR_W) begin : g_bad_area_slice
      $error("area field runs past the address width");
   end
   if (HALF_BIT >= AREA_LSB) begin : g_bad_half_bit
      $error("half-select bit must sit below the area field");
   end
   if (AREA_W < 1 || AREA_W > 4) begin : g_bad_area_count
      $error("area count out of supported range");
   end

   boot_mode_t         straps;
   boot_mode_t         mode_q;
   logic               mode_done;
   logic               capture_now;
   logic [FLAT_W-1:0]  widths_flat;

   assign straps = '{single_chip: strap_single, rom_en: strap_rom, wide_init: strap_wide};

   bcfg_mode_latch u_latch (
      .clk         (clk),
      .por_n       (por_n),
      .straps      (straps),
      .mode_q      (mode_q),
      .captured_q  (mode_done),
      .capture_now (capture_now)
   );

   bcfg_addr_decode #(
      .ADDR_W   (ADDR_W),
      .AREA_LSB (AREA_LSB),
      .AREA_W   (AREA_W),
      .HALF_BIT (HALF_BIT)
   ) u_dec (
      .addr        (acc_addr),
      .rom_en      (mode_q.rom_en),
      .single_chip (mode_q.single_chip),
      .area        (acc_area),
      .to_rom      (acc_rom),
      .to_ext      (acc_ext)
   );

   bcfg_width_bank #(
      .NUM_AREAS (NUM_AREAS),
      .AREA_W    (AREA_W),
      .WIDE_PAIR (WIDE_PAIR)
   ) u_bank (
      .clk         (clk),
      .por_n       (por_n),
      .load_init   (capture_now),
      .wide_strap  (strap_wide),
      .rom_en      (mode_q.rom_en),
      .wr_en       (cfg_we),
      .wr_area     (cfg_area),
      .wr_code     (cfg_wdata),
      .dec_area    (acc_area),
      .rd_code     (cfg_rdata),
      .dec_code    (acc_width),
      .widths_flat (widths_flat)
   );

   assign bus_standby  = mode_q.single_chip;
   assign pins_as_port = mode_q.single_chip;

endmodule

// File: rtl/bcfg_checker.sv
module bcfg_checker #(
   parameter int ADDR_W   = 29,
   parameter int AREA_W   = 3,
   parameter int AREA_LSB = 26,
   parameter int HALF_BIT = 25,
   localparam int FLAT_W  = (1 << AREA_W) * 2
)(
   input logic              clk,
   input logic              por_n,
   input logic              mode_done,
   input logic              rom_en_q,
   input logic              bus_standby,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_rom,
   input logic              acc_ext,
   input logic [FLAT_W-1:0] widths_flat
);

   function automatic logic has_reserved(input logic [FLAT_W-1:0] f);
      logic r;
      r = 1'b0;
      for (int i = 0; i < FLAT_W / 2; i++)
         if (f[i*2 +: 2] == 2'b11) r = 1'b1;
      return r;
   endfunction

   // R1: once captured, the mode seen at the ports does not move
   a_r1_mode_held: assert property (@(posedge clk) disable iff (!por_n)
      (mode_done && $past(mode_done)) |-> $stable(bus_standby));

   // R4: ROM and external targets never both claimed
   a_r4_targets_exclusive: assert property (@(posedge clk) disable iff (!por_n)
      !(acc_rom && acc_ext));

   // R4: a ROM hit only ever lies in the lower half of area 0
   a_r4_rom_lower_half: assert property (@(posedge clk) disable iff (!por_n)
      acc_rom |-> (acc_addr[AREA_LSB +: AREA_W] == '0 && !acc_addr[HALF_BIT]));

   // R5: single-chip mode never reaches external memory
   a_r5_standby_no_ext: assert property (@(posedge clk) disable iff (!por_n)
      bus_standby |-> !acc_ext);

   // R7: area 0 field frozen while ROM is off
   a_r7_area0_locked: assert property (@(posedge clk) disable iff (!por_n)
      (mode_done && $past(mode_done) && !rom_en_q) |-> widths_flat[1:0] == $past(widths_flat[1:0]));

   // R9: no field ever holds the reserved code
   a_r9_no_reserved: assert property (@(posedge clk) disable iff (!por_n)
      !has_reserved(widths_flat));

endmodule

bind bcfg_top bcfg_checker #(
   .ADDR_W   (ADDR_W),
   .AREA_W   (AREA_W),
   .AREA_LSB (AREA_LSB),
   .HALF_BIT (HALF_BIT)
) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .mode_done   (mode_done),
   .rom_en_q    (mode_q.rom_en),
   .bus_standby (bus_standby),
   .acc_addr    (acc_addr),
   .acc_rom     (acc_rom),
   .acc_ext     (acc_ext),
   .widths_flat (widths_flat)
);

// File: tb/bcfg_top_test.sv
`timescale 1ns/1ps
module bcfg_top_test;

   localparam int ADDR_W = 29;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              strap_single = 1'b0, strap_rom = 1'b0, strap_wide = 1'b0;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic [2:0]        acc_area;
   logic              acc_rom, acc_ext;
   logic [1:0]        acc_width;
   logic              cfg_we = 1'b0;
   logic [2:0]        cfg_area = '0;
   logic [1:0]        cfg_wdata = '0;
   logic [1:0]        cfg_rdata;
   logic              bus_standby, pins_as_port;

   int checks = 0;
   int fails  = 0;

   logic [1:0] model_w [8];
   logic       m_single, m_rom;

   always #10 clk = ~clk;   // 50 MHz

   bcfg_top uut (
      .clk(clk), .por_n(por_n),
      .strap_single(strap_single), .strap_rom(strap_rom), .strap_wide(strap_wide),
      .acc_addr(acc_addr), .acc_area(acc_area), .acc_rom(acc_rom), .acc_ext(acc_ext),
      .acc_width(acc_width), .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .bus_standby(bus_standby), .pins_as_port(pins_as_port)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] init_w(input logic wide);
      return wide ? 2'b01 : 2'b00;   // default pair: 8 / 16 bits
   endfunction

   function automatic logic exp_rom(input logic [ADDR_W-1:0] a);
      return m_rom && a[28:26] == 3'd0 && !a[25];
   endfunction

   task automatic power_on(input logic s, input logic r, input logic w);
      @(negedge clk);
      por_n = 1'b0;
      strap_single = s; strap_rom = r; strap_wide = w;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);   // capture edge has passed
      m_single = s; m_rom = r;
      for (int i = 0; i < 8; i++) model_w[i] = init_w(w);
   endtask

   task automatic write_field(input logic [2:0] a, input logic [1:0] d, input string req);
      @(negedge clk);
      cfg_we = 1'b1; cfg_area = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (d != 2'b11 && !(a == 3'd0 && !m_rom)) model_w[a] = d;
      #1 chk(req, cfg_rdata, model_w[a]);
   endtask

   task automatic check_decode(input logic [ADDR_W-1:0] a, input string req);
      logic er;
      acc_addr = a;
      #1;
      er = exp_rom(a);
      chk(req, acc_area, a[28:26]);
      chk(req, acc_rom, er);
      chk(req, acc_ext, !m_single && !er);
      chk("R10 acc_width", acc_width, model_w[a[28:26]]);
   endtask

   task automatic check_all_fields(input string req);
      for (int i = 0; i < 8; i++) begin
         cfg_area = 3'(i);
         #1 chk(req, cfg_rdata, model_w[i]);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      #1 chk("reset standby", bus_standby, 1'b0);

      // Session 1: external bus, ROM on, narrow
      power_on(1'b0, 1'b1, 1'b0);
      chk("R3 standby ext", bus_standby, 1'b0);
      chk("R3 port ext", pins_as_port, 1'b0);
      check_all_fields("R6 init narrow");
      strap_single = 1'b1; strap_rom = 1'b0; strap_wide = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 straps ignored standby", bus_standby, 1'b0);
      chk("R1 straps ignored port", pins_as_port, 1'b0);
      check_all_fields("R1 straps ignored widths");
      check_decode(29'h0000_0000, "R1 decode held");
      write_field(3'd0, 2'b10, "R8 area0 write rom on");
      write_field(3'd3, 2'b01, "R8 area3 write");
      write_field(3'd3, 2'b11, "R9 reserved ignored");
      write_field(3'd0, 2'b11, "R9 reserved area0");
      check_decode(29'h01FF_FFFF, "R4 last lower");
      check_decode(29'h0200_0000, "R4 first upper");
      check_decode(29'h03FF_FFFF, "R4 top area0");
      check_decode(29'h0400_0000, "R4 area1 start");
      for (int i = 0; i < 40; i++)
         write_field(3'($urandom_range(7)), 2'($urandom_range(3)), "R10 random write");
      for (int i = 0; i < 100; i++)
         check_decode(ADDR_W'($urandom), "R4 random decode");

      // Session 2: single-chip, ROM off, wide
      power_on(1'b1, 1'b0, 1'b1);
      chk("R2 standby relatched", bus_standby, 1'b1);
      chk("R3 port single", pins_as_port, 1'b1);
      check_all_fields("R2 R6 init wide");
      write_field(3'd0, 2'b10, "R7 area0 locked");
      write_field(3'd0, 2'b00, "R7 area0 locked again");
      write_field(3'd5, 2'b10, "R7 area5 open");
      check_decode(29'h0000_0010, "R5 single no rom no ext");
      for (int i = 0; i < 40; i++)
         write_field(3'($urandom_range(7)), 2'($urandom_range(3)), "R7 random write");
      for (int i = 0; i < 60; i++)
         check_decode(ADDR_W'($urandom), "R5 random decode single");

      // Session 3: external bus, ROM off
      power_on(1'b0, 1'b0, 1'b0);
      chk("R2 standby cleared", bus_standby, 1'b0);
      check_all_fields("R2 reload narrow");
      check_decode(29'h0000_0000, "R5 area0 low ext");
      check_decode(29'h01FF_FFFF, "R5 last lower ext");
      write_field(3'd0, 2'b01, "R7 area0 locked ext");
      for (int i = 0; i < 60; i++)
         check_decode(ADDR_W'($urandom), "R5 random decode ext");

      summary();
      $finish;
   end

endmodule